// File: doc/BRIEF.md
# Double-Banked Weight Replay Buffer

This block sits between a stream of weights arriving from memory and a compute array that consumes each weight set many times. It owns two storage banks. One bank is loaded from the input stream while the other bank is read out cyclically to the array. Once the loading bank is complete and the replaying bank has finished its last pass, the roles of the two banks swap. Either side that finishes first waits: the input by lowering `s_ready`, the output by lowering `m_valid`.

Every weight set starts with one configuration word. That word is decoded in the cycle it is accepted. It gives the kernel size, the channel count and the number of replay passes, and it sets the length of the set that follows. The low configuration bits go out on `m_user` with every output beat. Each bank keeps its own configuration, so a new header only affects the bank being loaded. There is no central controller and the pipeline never has to be flushed.

Top module: `wbuf_pingpong`

Two state machines do the work. The fill machine has the states FILL_HDR, FILL_DATA and FILL_DONE. It moves FILL_HDR to FILL_DATA when a header is accepted, FILL_DATA to FILL_DONE when the last weight of the set is accepted, and FILL_DONE to FILL_HDR on a swap. The replay machine has the states PLAY_IDLE and PLAY_RUN. It moves PLAY_IDLE to PLAY_RUN on a swap, and PLAY_RUN to PLAY_IDLE when the final beat of the final pass is issued. A swap happens exactly when the fill machine is in FILL_DONE and the replay machine is in PLAY_IDLE.

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1, and the first accepted input beat is taken as a header.
- R2: A header word holds the kernel size minus one in bits [3:0], the channel count minus one in bits [7:4] and the pass count minus one in bits [15:8]. Exactly (kernel+1)*(channel+1) weight beats follow it.
- R3: A stored set is emitted in arrival order, 0 to N-1, once per pass, for (pass field + 1) passes.
- R4: `m_user` on every output beat equals bits [7:0] of the header of the set that beat belongs to.
- R5: Banks swap only when a complete set is loaded and the previous set has finished all of its passes. While a loaded set waits, `s_ready` is 0. With nothing to replay, `m_valid` is 0.
- R6: A header with different settings does not change the passes, length or `m_user` of the set currently being replayed.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data`, `m_user` and `m_last` stay unchanged.
- R8: Under arbitrary gaps on `s_valid` and `m_ready`, sets come out in the order they went in, with no beat lost or repeated, and `m_last` is 1 exactly on the final beat of each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | DATA_W | Header word or weight |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Array accepts the output beat |
| m_data | output | DATA_W | Replayed weight |
| m_user | output | 8 | Channel and kernel fields of the set's header |
| m_last | output | 1 | Final beat of a replay pass |

## Verification
Bad bank or state bookkeeping shows up at the ports within one replay pass. It appears as a weight out of order or from the wrong set, an `m_user` that belongs to the next header, or `m_last` on the wrong beat. A wrong swap condition shows up sooner. Either `s_ready` returns while a loaded set is still waiting, or output from the new set starts before the old set's final pass is done. Each output beat is compared against a stream the bench builds from the headers it sends, so a single misplaced beat is seen in the cycle it is accepted.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int KW    = 4;           // kernel-size field width
    localparam int CW    = 4;           // channel-count field width
    localparam int RW    = 8;           // pass-count field width
    localparam int HDR_W = KW + CW + RW;
    localparam int AW    = KW + CW;     // bank address width
    localparam int UW    = KW + CW;     // sideband width

    typedef enum logic [1:0] {FILL_HDR, FILL_DATA, FILL_DONE} fill_state_t;
    typedef enum logic       {PLAY_IDLE, PLAY_RUN}            play_state_t;

    typedef struct packed {
        logic [RW-1:0] pass_m1;
        logic [CW-1:0] chan_m1;
        logic [KW-1:0] kern_m1;
        logic [AW-1:0] last_addr;
    } set_cfg_t;
endpackage

// File: rtl/wbuf_hdr_dec.sv
module wbuf_hdr_dec
    import wbuf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    output set_cfg_t          cfg
);
    logic [AW:0] k_cnt, c_cnt, prod;

    always_comb begin
        cfg.kern_m1   = word[KW-1:0];
        cfg.chan_m1   = word[KW+CW-1:KW];
        cfg.pass_m1   = word[HDR_W-1:KW+CW];
        k_cnt         = (AW+1)'(word[KW-1:0]) + 1'b1;
        c_cnt         = (AW+1)'(word[KW+CW-1:KW]) + 1'b1;
        prod          = k_cnt * c_cnt;
        cfg.last_addr = AW'(prod - 1'b1);
    end
endmodule

// File: rtl/wbuf_bank.sv
module wbuf_bank #(
    parameter int DATA_W = 16,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 2 ** AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/wbuf_oreg.sv
module wbuf_oreg #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            out_data  <= in_data;
        end
    end
endmodule

// File: rtl/wbuf_pingpong.sv
module wbuf_pingpong
    import wbuf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic [UW-1:0]     m_user,
    output logic              m_last
);
    localparam int NBANK = 2;
    localparam int OW    = DATA_W + UW + 1;

    fill_state_t fill_state, fill_next;
    play_state_t play_state, play_next;

    logic          wr_bank, rd_bank;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [RW-1:0] rd_pass;
    set_cfg_t      cfg [NBANK];
    set_cfg_t      hdr_cfg, rcfg, wcfg;
    logic [AW-1:0] rd_lim, wr_lim;

    logic s_fire, wr_we, swap, issue, pass_end, final_beat;
    logic p_v, p_bank, p_last, p_en;
    logic [UW-1:0]     p_user;
    logic [DATA_W-1:0] bank_q [NBANK];

    wbuf_hdr_dec #(.DATA_W(DATA_W)) u_dec (.word(s_data), .cfg(hdr_cfg));

    assign rcfg       = cfg[rd_bank];
    assign wcfg       = cfg[wr_bank];
    assign rd_lim     = rcfg.last_addr;
    assign wr_lim     = wcfg.last_addr;
    assign s_ready    = (fill_state != FILL_DONE);
    assign s_fire     = s_valid && s_ready;
    assign wr_we      = s_fire && (fill_state == FILL_DATA);
    assign swap       = (fill_state == FILL_DONE) && (play_state == PLAY_IDLE);
    assign issue      = (play_state == PLAY_RUN) && p_en;
    assign pass_end   = (rd_addr == rcfg.last_addr);
    assign final_beat = pass_end && (rd_pass == rcfg.pass_m1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_state <= FILL_HDR;
            play_state <= PLAY_IDLE;
        end else begin
            fill_state <= fill_next;
            play_state <= play_next;
        end
    end

    // Next-state logic
    always_comb begin
        fill_next = fill_state;
        unique case (fill_state)
            FILL_HDR:  if (s_fire) fill_next = FILL_DATA;
            FILL_DATA: if (s_fire && wr_addr == wcfg.last_addr) fill_next = FILL_DONE;
            FILL_DONE: if (swap) fill_next = FILL_HDR;
            default:   fill_next = FILL_HDR;
        endcase
        play_next = play_state;
        unique case (play_state)
            PLAY_IDLE: if (swap) play_next = PLAY_RUN;
            PLAY_RUN:  if (issue && final_beat) play_next = PLAY_IDLE;
            default:   play_next = PLAY_IDLE;
        endcase
    end

    // Counters, bank pointers, configuration and read pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
            rd_bank <= 1'b1;
            wr_addr <= '0;
            rd_addr <= '0;
            rd_pass <= '0;
            cfg[0]  <= '0;
            cfg[1]  <= '0;
            p_v     <= 1'b0;
            p_bank  <= 1'b0;
            p_last  <= 1'b0;
            p_user  <= '0;
        end else begin
            if (swap) begin
                wr_bank <= ~wr_bank;
                rd_bank <= wr_bank;
                rd_addr <= '0;
                rd_pass <= '0;
            end
            if (s_fire && fill_state == FILL_HDR) begin
                cfg[wr_bank] <= hdr_cfg;
                wr_addr      <= '0;
            end else if (wr_we) begin
                wr_addr <= wr_addr + 1'b1;
            end
            if (issue) begin
                if (pass_end) begin
                    rd_addr <= '0;
                    rd_pass <= rd_pass + 1'b1;
                end else begin
                    rd_addr <= rd_addr + 1'b1;
                end
            end
            if (p_en) begin
                p_v    <= issue;
                p_bank <= rd_bank;
                p_last <= pass_end;
                p_user <= {rcfg.chan_m1, rcfg.kern_m1};
            end
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        wbuf_bank #(.DATA_W(DATA_W), .AW(AW)) u_bank (
            .clk     (clk),
            .wr_en   (wr_we && (wr_bank == 1'(g))),
            .wr_addr (wr_addr),
            .wr_data (s_data),
            .rd_en   (issue && (rd_bank == 1'(g))),
            .rd_addr (rd_addr),
            .rd_data (bank_q[g])
        );
    end

    wbuf_oreg #(.W(OW)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (p_v),
        .in_ready  (p_en),
        .in_data   ({p_last, p_user, bank_q[p_bank]}),
        .out_valid (m_valid),
        .out_ready (m_ready),
        .out_data  ({m_last, m_user, m_data})
    );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk
    import wbuf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic [UW-1:0]     m_user,
    input logic              m_last,
    input fill_state_t       fill_state,
    input play_state_t       play_state,
    input logic              wr_bank,
    input logic              rd_bank,
    input logic [AW-1:0]     wr_addr,
    input logic [AW-1:0]     rd_addr,
    input logic [AW-1:0]     wr_lim,
    input logic [AW-1:0]     rd_lim
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_user) && $stable(m_last)); // R7

    AST_BANKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        play_state == PLAY_RUN |-> rd_bank != wr_bank); // R5

    AST_SWAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bank != $past(rd_bank) |-> $past(fill_state) == FILL_DONE && $past(play_state) == PLAY_IDLE); // R5

    AST_SWAP_STARTS_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_state) == FILL_DONE && fill_state == FILL_HDR |-> play_state == PLAY_RUN); // R5

    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        play_state == PLAY_RUN |-> rd_addr <= rd_lim); // R3

    AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_state == FILL_DATA |-> wr_addr <= wr_lim); // R2
endmodule

bind wbuf_pingpong wbuf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_user     (m_user),
    .m_last     (m_last),
    .fill_state (fill_state),
    .play_state (play_state),
    .wr_bank    (wr_bank),
    .rd_bank    (rd_bank),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .wr_lim     (wr_lim),
    .rd_lim     (rd_lim)
);

// File: tb/test_wbuf_pingpong.sv
module test_wbuf_pingpong;
    localparam int DW = 16;
    localparam int UWB = 8;
    localparam int EW = DW + UWB + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [DW-1:0] s_data = '0;
    logic m_valid;
    logic m_ready = 1'b0;
    logic [DW-1:0] m_data;
    logic [UWB-1:0] m_user;
    logic m_last;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit running  = 1'b0;
    bit hold_pend = 1'b0;
    logic [EW-1:0] held;
    logic [EW-1:0] exp_q [$];

    always #4 clk = ~clk;

    wbuf_pingpong #(.DATA_W(DW)) i_wbuf_pingpong (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_user(m_user), .m_last(m_last)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string what, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] make_hdr(input int k, input int c, input int r);
        return {8'(r), 4'(c), 4'(k)};
    endfunction

    task automatic send_beat(input logic [DW-1:0] d);
        bit done = 1'b0;
        while (!done) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                s_valid = 1'b0;
            end else begin
                s_valid = 1'b1;
                s_data  = d;
                done    = s_ready;
            end
        end
    endtask

    // Queue the expected replay stream, then load the set: header plus N weights.
    task automatic send_set(input int k, input int c, input int r);
        int n = (k + 1) * (c + 1);
        logic [DW-1:0] w [$];
        logic [DW-1:0] h = make_hdr(k, c, r);
        for (int i = 0; i < n; i++) w.push_back(DW'($urandom));
        for (int p = 0; p <= r; p++)
            for (int i = 0; i < n; i++)
                exp_q.push_back({(i == n - 1), h[UWB-1:0], w[i]});
        send_beat(h);
        for (int i = 0; i < n; i++) send_beat(w[i]);
    endtask

    // Output monitor: random backpressure, hold check, beat-by-beat comparison.
    always @(negedge clk) begin
        if (rst_n && running) begin
            logic [EW-1:0] now;
            logic [EW-1:0] exp;
            bit rdy;
            now = {m_last, m_user, m_data};
            if (hold_pend)
                check(m_valid && now == held, "R7 output changed under backpressure", now, held);
            rdy = ($urandom_range(0, 3) != 0);
            m_ready = rdy;
            if (m_valid && rdy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R8 unexpected output beat", now, '0);
                end else begin
                    exp = exp_q.pop_front();
                    check(now == exp, "R2/R3/R4/R6/R8 output beat", now, exp);
                end
            end
            hold_pend = m_valid && !rdy;
            held = now;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            check(1'b0, "watchdog expired", '0, '0);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_valid == 1'b0, "R1 m_valid after reset", EW'(m_valid), '0);
        check(s_ready == 1'b1, "R1 s_ready after reset", EW'(s_ready), EW'(1));
        running = 1'b1;

        // Directed: long replay of set A while set B loads, then B must wait (R5).
        send_set(1, 1, 19);
        send_set(0, 0, 0);
        @(negedge clk);
        s_valid = 1'b0;
        check(s_ready == 1'b0, "R5 loaded set waits while replay continues", EW'(s_ready), '0);

        // Directed: full-size set, then one-weight set with many passes (R2, R6).
        send_set(15, 15, 1);
        send_set(0, 0, 6);
        send_set(3, 0, 0);

        // Random sets with varied headers.
        for (int s = 0; s < 24; s++)
            send_set($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3));
        @(negedge clk);
        s_valid = 1'b0;

        while (exp_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        check(m_valid == 1'b0, "R5 no output when nothing is left to replay", EW'(m_valid), '0);
        check(s_ready == 1'b1, "R5 input open after last swap", EW'(s_ready), EW'(1));
        summary();
    end
endmodule